// File: doc/BRIEF.md
# Power-of-Two Period PWM Timer with Buffered Compare

This block is an 8-bit up-counting timer that drives a single pulse-width-modulated output. It counts only on a prescaled tick input. The period is not held in a register. It comes from the counter wrapping at 2^n − 1, where n is picked from a small set through a select field. A compare value decides how many ticks the output spends in its first level after each wrap. Each compare match and each wrap inverts an output flip-flop, so every period holds one full cycle of the waveform.

Software configures the timer through a narrow register write port. The usual sequence is as follows. Stop the timer. Clear the output flip-flop and enable inversion. Load the compare value. Then set the run bit. A compare buffer can be switched on so that a value written while the timer runs is loaded into the active compare only at the next wrap. Without the buffer, a new value acts at once. Stopping the timer clears the counter and freezes the output at its last level.

Top module: `pwm_pow2_timer`

## Requirements
- R1: After reset `pwm_out` is 0, the timer is stopped, inversion is disabled, the compare value is 0 and the buffer is off.
- R2: While running, the counter steps once per cycle with `tick` high. It wraps to 0 after 2^n − 1 ticks. Here n = min(6 + sel, 8), and sel is bits [2:1] of the control register (address 0). So sel 0..3 give periods of 63, 127, 255 and 255 ticks.
- R3: The output inverts on the tick that brings the counter to the compare value (address 1). Starting from a cleared flip-flop at count 0, the output is 0 for the first `cmp` ticks and then 1 until the wrap.
- R4: The tick on which the counter wraps inverts the output, so the output returns to 0 at the start of each period.
- R5: If the compare value is 0 or not below 2^n − 1, no match occurs. The output then inverts only at each wrap, at most once per tick.
- R6: With the inversion enable (bit 0 of the output register, address 2) at 0, ticks never change the output.
- R7: With the buffer enable (control bit 3) at 1, a compare write is held back. It becomes active only at the next wrap, so the current period finishes with the old value.
- R8: With the buffer enable at 0, a compare write is active from the next tick on.
- R9: Clearing the run bit (control bit 0) holds the counter at 0 and keeps the output at its current level, even with ticks present. Setting run again counts from 0.
- R10: A write to the output register with bit 1 set forces the output to 0, and one with bit 2 set forces it to 1. Clearing takes precedence over a wrap or match event in the same cycle.
- R11: Cycles with `tick` low change neither the counter nor the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 compare, 2 output control |
| wr_data | input | 8 | Write data |
| tick | input | 1 | Prescaled count enable |
| pwm_out | output | 1 | PWM output flip-flop |

## Verification
The bench aims at the period edges. If the match fired one count late, or the wrap counted 2^n ticks instead of 2^n − 1, the high phase would drift by a tick in every period. A compare value of 0, exactly 2^n − 1 or above it would, in a faulty design, invert twice in one tick or invert on an unreachable match, and the output would stop being a slow square wave. A buffered write made in the middle of a period must leave that period's edge where it was. A design that loaded the buffer at once would raise the output early. A design that never loaded it would keep the old width in the following period. Stop and restart are checked for a counter that is not cleared, which would shift every later edge. Idle cycles are checked for a counter that steps without a tick.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

   typedef enum logic [1:0] {
      REG_CTL  = 2'd0,
      REG_CMP  = 2'd1,
      REG_OUT  = 2'd2,
      REG_NONE = 2'd3
   } reg_addr_e;

   function automatic int unsigned wrap_bits(int unsigned base,
                                             int unsigned sel,
                                             int unsigned max_w);
      int unsigned n;
      n = base + sel;
      if (n > max_w) n = max_w;
      return n;
   endfunction

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
   import pwm_pkg::*;
#(
   parameter int CNT_W      = 8,
   parameter int SEL_W      = 2,
   parameter bit USE_BUFFER = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             ovf,
   output logic             run_o,
   output logic [SEL_W-1:0] sel_o,
   output logic [CNT_W-1:0] cmp_o,
   output logic             inv_o,
   output logic             clr_o,
   output logic             set_o
);

   localparam int BUF_BIT = SEL_W + 1;

   if (CNT_W < BUF_BIT + 1) begin : g_bad_width
      $error("pwm_regs: CNT_W too narrow for control fields");
   end

   logic ctl_wr, cmp_wr, out_wr;
   logic buf_q;
   logic [CNT_W-1:0] act_q;

   assign ctl_wr = wr_en && (wr_addr == REG_CTL);
   assign cmp_wr = wr_en && (wr_addr == REG_CMP);
   assign out_wr = wr_en && (wr_addr == REG_OUT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_o <= 1'b0;
         sel_o <= '0;
         buf_q <= 1'b0;
         inv_o <= 1'b0;
      end else begin
         if (ctl_wr) begin
            run_o <= wr_data[0];
            sel_o <= wr_data[SEL_W:1];
            buf_q <= wr_data[BUF_BIT];
         end
         if (out_wr) inv_o <= wr_data[0];
      end
   end

   assign clr_o = out_wr && wr_data[1];
   assign set_o = out_wr && wr_data[2];

   if (USE_BUFFER) begin : g_buffered
      logic [CNT_W-1:0] hold_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hold_q <= '0;
            act_q  <= '0;
         end else begin
            if (cmp_wr) hold_q <= wr_data;
            if (cmp_wr && !buf_q) act_q <= wr_data;
            else if (ovf && buf_q) act_q <= hold_q;
         end
      end

      // R7: held value moves across on a wrap
      a_r7_buffer_load: assert property (@(posedge clk) disable iff (!rst_n)
         (buf_q && ovf) |=> (act_q == $past(hold_q)))
         else $error("a_r7_buffer_load");

      // R8: direct compare write
      a_r8_direct_write: assert property (@(posedge clk) disable iff (!rst_n)
         (cmp_wr && !buf_q) |=> (act_q == $past(wr_data)))
         else $error("a_r8_direct_write");
   end else begin : g_direct
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) act_q <= '0;
         else if (cmp_wr) act_q <= wr_data;
      end

      a_r8_direct_write: assert property (@(posedge clk) disable iff (!rst_n)
         cmp_wr |=> (act_q == $past(wr_data)))
         else $error("a_r8_direct_write");
   end

   assign cmp_o = act_q;

endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
   import pwm_pkg::*;
#(
   parameter int CNT_W  = 8,
   parameter int SEL_W  = 2,
   parameter int N_BASE = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic [SEL_W-1:0] sel,
   input  logic [CNT_W-1:0] cmp,
   output logic             ovf,
   output logic             match
);

   localparam int NUM_SEL = 1 << SEL_W;

   if (N_BASE < 1 || N_BASE > CNT_W) begin : g_bad_base
      $error("pwm_counter: N_BASE out of range");
   end

   logic [CNT_W-1:0] top_tab [NUM_SEL];

   for (genvar i = 0; i < NUM_SEL; i++) begin : g_top
      localparam int unsigned NB = wrap_bits(N_BASE, i, CNT_W);
      assign top_tab[i] = CNT_W'((64'd1 << NB) - 64'd1);
   end

   logic [CNT_W-1:0] top, cnt_q;
   logic [CNT_W:0]   nxt;
   logic             step;

   assign top   = top_tab[sel];
   assign step  = run && tick;
   assign nxt   = {1'b0, cnt_q} + (CNT_W+1)'(1);
   assign ovf   = step && (nxt >= {1'b0, top});
   assign match = step && !ovf && (nxt == {1'b0, cmp});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (!run)   cnt_q <= '0;
      else if (ovf)    cnt_q <= '0;
      else if (step)   cnt_q <= nxt[CNT_W-1:0];
   end

   // R9: a stopped timer sits at zero
   a_r9_stop_clear: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (cnt_q == '0))
      else $error("a_r9_stop_clear");

   // R11: no tick, no step
   a_r11_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !tick) |=> $stable(cnt_q))
      else $error("a_r11_hold_idle");

   // R5: at most one inverting event per tick
   a_r5_single_event: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({ovf, match}) <= 1)
      else $error("a_r5_single_event");

endmodule

// File: rtl/pwm_outff.sv
module pwm_outff (
   input  logic clk,
   input  logic rst_n,
   input  logic evt,
   input  logic inv_en,
   input  logic clr,
   input  logic set,
   output logic ff_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              ff_q <= 1'b0;
      else if (clr)            ff_q <= 1'b0;
      else if (set)            ff_q <= 1'b1;
      else if (evt && inv_en)  ff_q <= ~ff_q;
   end

   // R10: clear wins over everything
   a_r10_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !ff_q)
      else $error("a_r10_clear_wins");

   // R6: inversion disabled keeps the level
   a_r6_no_inversion: assert property (@(posedge clk) disable iff (!rst_n)
      (!inv_en && !clr && !set) |=> $stable(ff_q))
      else $error("a_r6_no_inversion");

   // R3: an enabled event flips the level
   a_r3_event_flips: assert property (@(posedge clk) disable iff (!rst_n)
      (evt && inv_en && !clr && !set) |=> (ff_q != $past(ff_q)))
      else $error("a_r3_event_flips");

endmodule

// File: rtl/pwm_pow2_timer.sv
module pwm_pow2_timer
   import pwm_pkg::*;
#(
   parameter int CNT_W      = 8,
   parameter int SEL_W      = 2,
   parameter int N_BASE     = 6,
   parameter bit USE_BUFFER = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             tick,
   output logic             pwm_out
);

   logic             run, inv_en, clr_p, set_p, ovf, match;
   logic [SEL_W-1:0] sel;
   logic [CNT_W-1:0] cmp_act;

   pwm_regs #(.CNT_W(CNT_W), .SEL_W(SEL_W), .USE_BUFFER(USE_BUFFER)) i_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .ovf(ovf), .run_o(run), .sel_o(sel),
      .cmp_o(cmp_act), .inv_o(inv_en), .clr_o(clr_p), .set_o(set_p)
   );

   pwm_counter #(.CNT_W(CNT_W), .SEL_W(SEL_W), .N_BASE(N_BASE)) i_counter (
      .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .sel(sel),
      .cmp(cmp_act), .ovf(ovf), .match(match)
   );

   pwm_outff i_outff (
      .clk(clk), .rst_n(rst_n), .evt(ovf || match), .inv_en(inv_en),
      .clr(clr_p), .set(set_p), .ff_q(pwm_out)
   );

endmodule

// File: tb/test_pwm_pow2_timer.sv
module test_pwm_pow2_timer;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = 2'd0;
   logic [7:0] wr_data = 8'd0;
   logic       tick = 1'b0;
   logic       pwm_out;

   pwm_pow2_timer i_pwm_pow2_timer (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .tick(tick), .pwm_out(pwm_out)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   typedef struct {
      int    due;
      bit    exp;
      string req;
      int    k;
   } item_t;

   item_t sb[$];
   int cyc = 0;
   int checks = 0;
   int errors = 0;
   int k = 0;
   int g_top = 63, g_a = 0, g_b = 0, g_sw = 0;
   bit g_inv = 1'b0;

   always @(posedge clk) cyc++;

   // Monitor: pop expected levels whose cycle has come
   always @(negedge clk) begin
      while (sb.size() > 0 && sb[0].due <= cyc) begin
         item_t it;
         it = sb.pop_front();
         checks++;
         if (pwm_out !== it.exp) begin
            errors++;
            $display("FAIL %s: tick %0d pwm_out=%0b expected %0b",
                     it.req, it.k, pwm_out, it.exp);
         end
      end
   end

   function automatic bit model(int kk);
      int c;
      if (!g_inv) return 1'b0;
      c = (kk <= g_sw) ? g_a : g_b;
      if (c > 0 && c < g_top) return (kk % g_top) >= c;
      return ((kk / g_top) % 2) == 1;
   endfunction

   task automatic chk(bit act, bit exp, string req);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: pwm_out=%0b expected %0b", req, act, exp);
      end
   endtask

   task automatic wr(int a, int d);
      @(negedge clk);
      tick    = 1'b0;
      wr_en   = 1'b1;
      wr_addr = 2'(a);
      wr_data = 8'(d);
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic tick_n(int count, string req);
      for (int i = 0; i < count; i++) begin
         item_t it;
         @(negedge clk);
         tick = 1'b1;
         k++;
         it.due = cyc + 1;
         it.exp = model(k);
         it.req = req;
         it.k   = k;
         sb.push_back(it);
      end
      @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic idle_n(int count, string req);
      for (int i = 0; i < count; i++) begin
         item_t it;
         @(negedge clk);
         tick = 1'b0;
         it.due = cyc + 1;
         it.exp = model(k);
         it.req = req;
         it.k   = k;
         sb.push_back(it);
      end
   endtask

   task automatic start(int sel, int bufm, int c);
      int n;
      wr(0, sel << 1);
      wr(1, 3);          // wrong address on purpose is avoided: output reg below
      wr(2, 3);          // inversion on, clear flip-flop
      wr(1, c);
      wr(0, (bufm << 3) | (sel << 1) | 1);
      n = 6 + sel;
      if (n > 8) n = 8;
      k = 0;
      g_top = (1 << n) - 1;
      g_a = c;
      g_b = c;
      g_sw = 0;
      g_inv = 1'b1;
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: run did not end, expected completion");
      summary();
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(pwm_out, 1'b0, "R1 reset level");

      // R2 R3 R4: n=7, compare 72
      start(1, 0, 72);
      tick_n(254, "R2 R3 R4 n=7 cmp=72");
      idle_n(6, "R11 idle cycles");
      tick_n(100, "R3 after idle");

      // R9: stop holds level (position 100 of 127 is high)
      wr(0, 1 << 1);
      repeat (2) @(negedge clk);
      chk(pwm_out, 1'b1, "R9 hold on stop");
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         tick = 1'b1;
      end
      @(negedge clk);
      tick = 1'b0;
      @(negedge clk);
      chk(pwm_out, 1'b1, "R9 ticks ignored while stopped");

      // R10: force clear and set
      wr(2, 3);
      chk(pwm_out, 1'b0, "R10 clear");
      wr(2, 5);
      chk(pwm_out, 1'b1, "R10 set");

      // R2 other sizes; restart from 0 (R9)
      start(0, 0, 20);
      tick_n(130, "R2 R9 n=6 restart");
      start(2, 0, 200);
      tick_n(300, "R2 n=8");
      start(3, 0, 10);
      tick_n(260, "R2 sel=3 clamps n=8");

      // R5: unreachable or zero compare
      start(0, 0, 0);
      tick_n(130, "R5 cmp=0");
      start(0, 0, 63);
      tick_n(130, "R5 cmp=top");
      start(0, 0, 100);
      tick_n(130, "R5 cmp>top");

      // R6: inversion disabled
      start(0, 0, 20);
      wr(2, 2);
      g_inv = 1'b0;
      tick_n(130, "R6 no inversion");

      // R7: buffered write mid-period
      start(0, 1, 20);
      tick_n(30, "R7 before write");
      wr(1, 40);
      g_b = 40;
      g_sw = 63;
      tick_n(100, "R7 buffered compare");

      // R8: unbuffered write mid-period
      start(0, 0, 20);
      tick_n(10, "R8 before write");
      wr(1, 30);
      g_b = 30;
      g_sw = 10;
      tick_n(120, "R8 immediate compare");
      idle_n(3, "R11 trailing idle");

      repeat (4) @(negedge clk);
      summary();
      $finish;
   end

endmodule